// File: doc/BRIEF.md
# UART Byte FIFO Pair with Debug Access

This block holds the two byte-wide queues of a serial port. On the transmit side the CPU pushes bytes and the serializer pops them. On the receive side the deserializer pushes bytes and the CPU pops them. Each queue is eight entries deep and reports how many entries it holds. Popped bytes appear on registered outputs one clock after the pop strobe. A pop from an empty queue leaves the output at its last value. A push to a full queue is dropped.

A debug path runs against the normal data direction and is gated by a debug-enable input. A debug read pops the transmit queue, so software can see what is waiting to go out. A debug write pushes into the receive queue, so software can inject received data. When the gate is closed, debug writes do nothing and debug reads return zero. A constant output tells software that real queues are fitted rather than single holding registers.

Top module: `uart_fifo_pair`

## Requirements
- R1: `fifosPresent` is 1 at all times, including during reset.
- R2: A `cpuTxWrite` pulse stores `cpuTxData`. Each `serTxPop` on a non-empty transmit queue puts the oldest byte on `serTxData` one clock later, in write order.
- R3: A `desRxPush` pulse stores `desRxData`. Each `cpuRxPop` on a non-empty receive queue puts the oldest byte on `cpuRxData` one clock later, in push order.
- R4: A `dbgRead` with `dbgEnable` high pops the transmit queue. The popped byte appears on `dbgRdata[7:0]` one clock later. `dbgRdata[31:8]` is always zero.
- R5: A `dbgWrite` with `dbgEnable` high pushes `dbgWdata[7:0]` into the receive queue.
- R6: While `dbgEnable` is low, `dbgWrite` leaves the receive queue unchanged. `dbgRead` leaves the transmit queue unchanged and sets `dbgRdata` to zero one clock later.
- R7: A push to a queue holding 8 entries is dropped. The count stays 8 and the stored bytes are unchanged.
- R8: A pop from an empty queue leaves its data output at the last popped value, and the count stays 0.
- R9: `txCount` and `rxCount` give the number of stored entries, 0 to 8, and update one clock after each push or pop.
- R10: A `serTxPop` and an enabled `dbgRead` in the same cycle remove one byte only. That byte appears on both `serTxData` and `dbgRdata[7:0]`.
- R11: A `desRxPush` and an enabled `dbgWrite` in the same cycle store only the `desRxData` byte. The debug byte is dropped.
- R12: After reset both counts are 0 and `serTxData`, `cpuRxData` and `dbgRdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dbgEnable | input | 1 | Opens the debug path |
| cpuTxWrite | input | 1 | CPU push strobe for the transmit queue |
| cpuTxData | input | 8 | Byte to transmit |
| serTxPop | input | 1 | Serializer pop strobe |
| serTxData | output | 8 | Last byte popped by the serializer |
| desRxPush | input | 1 | Deserializer push strobe |
| desRxData | input | 8 | Received byte |
| cpuRxPop | input | 1 | CPU pop strobe for the receive queue |
| cpuRxData | output | 8 | Last byte popped by the CPU |
| dbgRead | input | 1 | Debug read strobe (pops the transmit queue) |
| dbgRdata | output | 32 | Debug read value, byte in bits 7:0 |
| dbgWrite | input | 1 | Debug write strobe (pushes the receive queue) |
| dbgWdata | input | 32 | Debug write value, byte in bits 7:0 |
| txCount | output | 4 | Transmit queue occupancy |
| rxCount | output | 4 | Receive queue occupancy |
| fifosPresent | output | 1 | Constant 1: queues are fitted |

## Verification
A vector table interleaves CPU writes with serializer and debug pops on the transmit side. Byte order then shows whether both consumers share one read pointer. On the receive side, deserializer pushes alternate with debug writes, which shows that both producers share one write pointer. Directed runs fill a queue past capacity and drain it past empty, so a dropped ninth byte can be told apart from an overwrite and a held value from a stale pointer. Gated debug accesses, and pops and pushes issued together, separate the enable gating from the priority between the two ports on each queue.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic serLoad;
    logic cpuLoad;
    logic dbgLoad;
    logic dbgClear;
    logic rxFromDbg;
  } fifoStrobes_t;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == CW'(DEPTH)) && $stable(wrPtr));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> (count == '0) && $stable(rdPtr));
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         dbgEnable,
  input  logic         cpuTxWrite,
  input  logic         serTxPop,
  input  logic         desRxPush,
  input  logic         cpuRxPop,
  input  logic         dbgRead,
  input  logic         dbgWrite,
  input  logic         txFull,
  input  logic         txEmpty,
  input  logic         rxFull,
  input  logic         rxEmpty,
  output fifoStrobes_t strobes
);
  logic dbgRdOk, dbgWrOk;

  assign dbgRdOk = dbgRead && dbgEnable;
  assign dbgWrOk = dbgWrite && dbgEnable;

  always_comb begin
    strobes           = '0;
    strobes.txPush    = cpuTxWrite && !txFull;
    strobes.txPop     = (serTxPop || dbgRdOk) && !txEmpty;
    strobes.serLoad   = serTxPop && !txEmpty;
    strobes.dbgLoad   = dbgRdOk && !txEmpty;
    strobes.dbgClear  = dbgRead && !dbgEnable;
    strobes.rxFromDbg = !desRxPush;
    strobes.rxPush    = (desRxPush || dbgWrOk) && !rxFull;
    strobes.rxPop     = cpuRxPop && !rxEmpty;
    strobes.cpuLoad   = cpuRxPop && !rxEmpty;
  end

  // R11: the serial side owns the receive write port when both push.
  assert_rx_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    desRxPush |-> !strobes.rxFromDbg);
  // R6: a gated debug access never moves a queue on its own.
  assert_dbg_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgEnable && !serTxPop) |-> !strobes.txPop);
endmodule

// File: rtl/uart_fifo_datapath.sv
module uart_fifo_datapath
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  fifoStrobes_t strobes,
  input  logic [7:0]   cpuTxData,
  input  logic [7:0]   desRxData,
  input  logic [7:0]   dbgByte,
  output logic [7:0]   serTxData,
  output logic [7:0]   cpuRxData,
  output logic [7:0]   dbgByteOut,
  output logic         txFull,
  output logic         txEmpty,
  output logic         rxFull,
  output logic         rxEmpty,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount
);
  logic [7:0] txHead, rxHead, rxWrData;

  assign rxWrData = strobes.rxFromDbg ? dbgByte : desRxData;

  uart_byte_fifo #(.WIDTH(8), .DEPTH(DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .push(strobes.txPush), .pop(strobes.txPop),
    .wrData(cpuTxData), .headData(txHead), .full(txFull), .empty(txEmpty),
    .count(txCount));

  uart_byte_fifo #(.WIDTH(8), .DEPTH(DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .push(strobes.rxPush), .pop(strobes.rxPop),
    .wrData(rxWrData), .headData(rxHead), .full(rxFull), .empty(rxEmpty),
    .count(rxCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serTxData  <= '0;
      cpuRxData  <= '0;
      dbgByteOut <= '0;
    end else begin
      if (strobes.serLoad) serTxData <= txHead;
      if (strobes.cpuLoad) cpuRxData <= rxHead;
      if (strobes.dbgClear)     dbgByteOut <= '0;
      else if (strobes.dbgLoad) dbgByteOut <= txHead;
    end
  end

  // R10: a shared pop hands the same byte to both readers.
  assert_pair_pop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.serLoad && strobes.dbgLoad) |=> (serTxData == dbgByteOut));
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dbgEnable,
  input  logic          cpuTxWrite,
  input  logic [7:0]    cpuTxData,
  input  logic          serTxPop,
  output logic [7:0]    serTxData,
  input  logic          desRxPush,
  input  logic [7:0]    desRxData,
  input  logic          cpuRxPop,
  output logic [7:0]    cpuRxData,
  input  logic          dbgRead,
  output logic [31:0]   dbgRdata,
  input  logic          dbgWrite,
  input  logic [31:0]   dbgWdata,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic          fifosPresent
);
  fifoStrobes_t strobes;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic [7:0] dbgByteOut;

  uart_fifo_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .dbgEnable(dbgEnable), .cpuTxWrite(cpuTxWrite),
    .serTxPop(serTxPop), .desRxPush(desRxPush), .cpuRxPop(cpuRxPop),
    .dbgRead(dbgRead), .dbgWrite(dbgWrite), .txFull(txFull),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty), .strobes(strobes));

  uart_fifo_datapath #(.DEPTH(DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuTxData(cpuTxData),
    .desRxData(desRxData), .dbgByte(dbgWdata[7:0]), .serTxData(serTxData),
    .cpuRxData(cpuRxData), .dbgByteOut(dbgByteOut), .txFull(txFull),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txCount(txCount), .rxCount(rxCount));

  assign dbgRdata     = {24'd0, dbgByteOut};
  assign fifosPresent = 1'b1;

  assert_dbg_off_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dbgRead && !dbgEnable) |=> (dbgRdata == 32'd0) && $stable(txCount));
  assert_dbg_off_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dbgWrite && !dbgEnable && !desRxPush && !cpuRxPop) |=> $stable(rxCount));
endmodule

// File: tb/test_uart_fifo_pair.sv
module test_uart_fifo_pair;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dbgEnable = 1'b0, cpuTxWrite = 1'b0, serTxPop = 1'b0;
  logic desRxPush = 1'b0, cpuRxPop = 1'b0, dbgRead = 1'b0, dbgWrite = 1'b0;
  logic [7:0] cpuTxData = '0, desRxData = '0;
  logic [31:0] dbgWdata = '0;
  logic [7:0] serTxData, cpuRxData;
  logic [31:0] dbgRdata;
  logic [3:0] txCount, rxCount;
  logic fifosPresent;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_fifo_pair i_uart_fifo_pair (
    .clk(clk), .rstN(rstN), .dbgEnable(dbgEnable), .cpuTxWrite(cpuTxWrite),
    .cpuTxData(cpuTxData), .serTxPop(serTxPop), .serTxData(serTxData),
    .desRxPush(desRxPush), .desRxData(desRxData), .cpuRxPop(cpuRxPop),
    .cpuRxData(cpuRxData), .dbgRead(dbgRead), .dbgRdata(dbgRdata),
    .dbgWrite(dbgWrite), .dbgWdata(dbgWdata), .txCount(txCount),
    .rxCount(rxCount), .fifosPresent(fifosPresent));

  // ops: 0 tx write, 1 serializer pop, 2 rx push, 3 cpu pop, 4 dbg read, 5 dbg write
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {4'd0, 8'hA1, 8'h00}, {4'd0, 8'hB2, 8'h00}, {4'd0, 8'hC3, 8'h00},
    {4'd1, 8'h00, 8'hA1}, {4'd4, 8'h00, 8'hB2}, {4'd1, 8'h00, 8'hC3},
    {4'd2, 8'h11, 8'h00}, {4'd5, 8'h22, 8'h00}, {4'd2, 8'h33, 8'h00},
    {4'd3, 8'h00, 8'h11}, {4'd3, 8'h00, 8'h22}, {4'd3, 8'h00, 8'h33}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive strobes at a falling edge, let one rising edge pass, then release.
  task automatic doOp(input logic [3:0] op, input logic [7:0] d);
    case (op)
      4'd0: begin cpuTxWrite = 1'b1; cpuTxData = d; end
      4'd1: serTxPop = 1'b1;
      4'd2: begin desRxPush = 1'b1; desRxData = d; end
      4'd3: cpuRxPop = 1'b1;
      4'd4: dbgRead = 1'b1;
      default: begin dbgWrite = 1'b1; dbgWdata = {24'hFFFFFF, d}; end
    endcase
    @(negedge clk);
    cpuTxWrite = 1'b0; serTxPop = 1'b0; desRxPush = 1'b0;
    cpuRxPop = 1'b0; dbgRead = 1'b0; dbgWrite = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    check("R1 in reset", {31'd0, fifosPresent}, 32'd1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 txCount", {28'd0, txCount}, 32'd0);
    check("R12 rxCount", {28'd0, rxCount}, 32'd0);
    check("R12 data", {8'd0, serTxData, cpuRxData, 8'd0} | dbgRdata, 32'd0);
    check("R1", {31'd0, fifosPresent}, 32'd1);

    dbgEnable = 1'b1;
    for (int i = 0; i < NV; i++) begin
      doOp(VEC[i][19:16], VEC[i][15:8]);
      case (VEC[i][19:16])
        4'd1: check("R2 serializer order", {24'd0, serTxData}, {24'd0, VEC[i][7:0]});
        4'd3: check("R3/R5 cpu order", {24'd0, cpuRxData}, {24'd0, VEC[i][7:0]});
        4'd4: check("R4 debug read", dbgRdata, {24'd0, VEC[i][7:0]});
        default: ;
      endcase
    end
    check("R9 tx drained", {28'd0, txCount}, 32'd0);
    check("R9 rx drained", {28'd0, rxCount}, 32'd0);

    // Fill past capacity: ninth byte is dropped.
    for (int i = 0; i < 9; i++) doOp(4'd0, 8'(8'h40 + i));
    check("R7 full count", {28'd0, txCount}, 32'd8);
    for (int i = 0; i < 8; i++) begin
      doOp(4'd1, 8'h00);
      check("R7 contents", {24'd0, serTxData}, {24'd0, 8'(8'h40 + i)});
    end
    doOp(4'd1, 8'h00);
    check("R8 empty pop holds", {24'd0, serTxData}, 32'h47);
    check("R8 count zero", {28'd0, txCount}, 32'd0);
    doOp(4'd3, 8'h00);
    check("R8 rx empty pop holds", {24'd0, cpuRxData}, 32'h33);

    // R10: serializer pop and debug read together.
    doOp(4'd0, 8'h5A);
    doOp(4'd0, 8'h6B);
    serTxPop = 1'b1; dbgRead = 1'b1;
    @(negedge clk);
    serTxPop = 1'b0; dbgRead = 1'b0;
    check("R10 ser byte", {24'd0, serTxData}, 32'h5A);
    check("R10 dbg byte", dbgRdata, 32'h5A);
    check("R10 one removed", {28'd0, txCount}, 32'd1);

    // R11: deserializer push and debug write together.
    desRxPush = 1'b1; desRxData = 8'h77; dbgWrite = 1'b1; dbgWdata = 32'h88;
    @(negedge clk);
    desRxPush = 1'b0; dbgWrite = 1'b0;
    check("R11 one stored", {28'd0, rxCount}, 32'd1);
    doOp(4'd3, 8'h00);
    check("R11 serial byte kept", {24'd0, cpuRxData}, 32'h77);

    // R6: gated debug path.
    dbgEnable = 1'b0;
    doOp(4'd5, 8'h99);
    check("R6 write ignored", {28'd0, rxCount}, 32'd0);
    doOp(4'd4, 8'h00);
    check("R6 read zero", dbgRdata, 32'd0);
    check("R6 tx untouched", {28'd0, txCount}, 32'd1);
    dbgEnable = 1'b1;
    doOp(4'd4, 8'h00);
    check("R4 enabled read upper zero", dbgRdata, 32'h6B);
    doOp(4'd5, 8'hE5);
    doOp(4'd3, 8'h00);
    check("R5 debug write low byte", {24'd0, cpuRxData}, 32'hE5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule